// File: doc/BRIEF.md
# Programmable LCD panel timing generator

This block produces the scan timing for a TFT panel from a handful of programmed words. An internal divider derives a pixel clock enable from the system clock. On each enabled cycle, a horizontal counter and a vertical counter step through the active region and then the blanking intervals. Horizontal sync, vertical sync and data enable are decoded from the counter position. Each of these outputs, and a pixel-clock-edge select, has its own polarity bit.

A word-addressed register port loads the programmed words: the panel size, a horizontal timing word, a vertical timing word and a panel configuration word. The same port reads them back and also serves an end-of-frame interrupt enable and status pair. The generator has no enable bit and starts scanning as soon as reset is released, using defined reset values. All programmed values are copied into a working set only when the scan wraps to its first pixel, so a frame never mixes old and new timing.

Pixel data is not fetched here. The incoming pixel word is passed to the output while the active region is being scanned, and is forced to zero outside it.

Top module: `panel_tgen`

## Requirements
- R1: After reset, `x_cnt` and `y_cnt` are 0, `irq` is 0, the status bit is 0, and the size word reads back as width 4 units and height 64 lines. All other registers read 0.
- R2: The configuration word (address 3) holds a divide field in bits 5:0. `pclk_en` is high on one system clock in every (field+1). A field of 0 makes it high on every clock.
- R3: The horizontal timing word (address 1) holds the sync length minus 1 in bits 31:26, the front porch minus 1 in bits 15:8, and the back porch minus 3 in bits 7:0. The size word (address 0) holds the active width divided by 16 in bits 25:20. Each line runs active pixels, then front porch, then sync, then back porch. The horizontal sync is active during the sync part.
- R4: The vertical timing word (address 2) uses the same bit positions for vertical sync, front porch and back porch, counted in lines with no bias. The active height in lines is in bits 9:0 of the size word. Lines follow the same order, and vertical sync is active during the sync lines.
- R5: Data enable is active exactly when the counters are inside the active width and height. `pix_out` equals `pix_in` there and is 0 elsewhere. Data enable never overlaps either sync.
- R6: In the configuration word, bit 22 inverts `hsync`, bit 23 inverts `vsync`, bit 20 inverts `de`, and bit 21 is driven on `pclk_inv`. A 1 selects the active-low or inverted sense.
- R7: Writes to the size, timing and configuration words take effect only when the scan wraps from the last pixel of the last line to pixel 0 of line 0.
- R8: Bit 1 of the status register (address 5) is set on the clock after the pixel enable that covers the last active pixel of the last active line. Writing 1 to bit 1 clears it. Writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R9: `irq` is high exactly when status bit 1 and bit 1 of the enable register (address 4) are both 1.
- R10: Reads return the stored fields at their bit positions with all other bits 0. Addresses 6 and 7 read 0.
- R11: The counters change only on cycles where `pclk_en` is high. `x_cnt` steps by 1 and wraps to 0 after the back porch. `y_cnt` steps on each horizontal wrap and returns to 0 after the vertical back porch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pix_in | input | DATA_W | Pixel word from the upstream source |
| pix_out | output | DATA_W | Pixel word gated by the active region |
| pclk_en | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pclk_inv | output | 1 | Selected pixel clock edge (1 = inverted) |
| x_cnt | output | CNT_W | Current pixel position within the line |
| y_cnt | output | CNT_W | Current line within the frame |
| irq | output | 1 | End-of-frame interrupt |

## Verification
The bench targets three places where a single bias or a single latch point decides the outcome.

- **Biased horizontal fields.** A design that dropped the minus-3 back porch bias or the minus-1 sync bias would produce lines of the wrong length. The bench measures whole-frame lengths in pixel enables, so this shows up directly.
- **Timing changes mid-frame.** Timing is rewritten during a frame. A design that applied it at once would stretch or shorten the running frame and put sync in the wrong place.
- **Status and enable corner cases.** The bench clears the status bit, writes 0 to it, and masks the enable. A design that cleared on any write, or ignored the enable, would show the wrong `irq` level.

A changed divider ratio and inverted polarities are also compared against the reference on every cycle.

// File: rtl/panel_tgen_pkg.sv
package panel_tgen_pkg;

    localparam int REG_ADDR_W = 3;

    // word addresses of the register port
    localparam logic [REG_ADDR_W-1:0] A_SIZE = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_HTIM = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_VTIM = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_CFG  = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_IEN  = 3'd4;
    localparam logic [REG_ADDR_W-1:0] A_IST  = 3'd5;

    // field positions
    localparam int F_WU_LO  = 20;
    localparam int F_H_LO   = 0;
    localparam int F_SW_LO  = 26;
    localparam int F_FP_LO  = 8;
    localparam int F_BP_LO  = 0;
    localparam int F_DIV_LO = 0;
    localparam int B_INV_DE = 20;
    localparam int B_INV_PC = 21;
    localparam int B_INV_HS = 22;
    localparam int B_INV_VS = 23;
    localparam int B_EOF    = 1;

    // field widths
    localparam int WU_W  = 6;
    localparam int HT_W  = 10;
    localparam int SW_W  = 6;
    localparam int PR_W  = 8;
    localparam int DIV_W = 6;

    // biases of the horizontal fields
    localparam int HSW_BIAS = 1;
    localparam int HFP_BIAS = 1;
    localparam int HBP_BIAS = 3;
    localparam int UNIT_SH  = 4;   // width unit = 16 pixels

    typedef struct packed {
        logic [WU_W-1:0]  w_units;
        logic [HT_W-1:0]  height;
        logic [SW_W-1:0]  hsw;
        logic [PR_W-1:0]  hfp;
        logic [PR_W-1:0]  hbp;
        logic [SW_W-1:0]  vsw;
        logic [PR_W-1:0]  vfp;
        logic [PR_W-1:0]  vbp;
        logic [DIV_W-1:0] div;
        logic             inv_hs;
        logic             inv_vs;
        logic             inv_de;
        logic             inv_pc;
    } tgen_cfg_t;

    function automatic tgen_cfg_t reset_cfg(input int wu, input int h);
        tgen_cfg_t c;
        c = '0;
        c.w_units = WU_W'(wu);
        c.height  = HT_W'(h);
        return c;
    endfunction

endpackage

// File: rtl/panel_tgen_regs.sv
module panel_tgen_regs
    import panel_tgen_pkg::*;
#(
    parameter int RST_WUNITS = 4,
    parameter int RST_HEIGHT = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [31:0]           wdata,
    input  logic                  eof_set,
    output tgen_cfg_t             cfg,
    output logic [31:0]           rdata,
    output logic                  ien,
    output logic                  eof_st,
    output logic                  irq
);

    localparam tgen_cfg_t RST_CFG = reset_cfg(RST_WUNITS, RST_HEIGHT);

    typedef struct packed {
        tgen_cfg_t cfg;
        logic      ien;
        logic      eof;
    } regs_state_t;

    regs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            unique case (addr)
                A_SIZE: begin
                    st_d.cfg.w_units = wdata[F_WU_LO +: WU_W];
                    st_d.cfg.height  = wdata[F_H_LO +: HT_W];
                end
                A_HTIM: begin
                    st_d.cfg.hsw = wdata[F_SW_LO +: SW_W];
                    st_d.cfg.hfp = wdata[F_FP_LO +: PR_W];
                    st_d.cfg.hbp = wdata[F_BP_LO +: PR_W];
                end
                A_VTIM: begin
                    st_d.cfg.vsw = wdata[F_SW_LO +: SW_W];
                    st_d.cfg.vfp = wdata[F_FP_LO +: PR_W];
                    st_d.cfg.vbp = wdata[F_BP_LO +: PR_W];
                end
                A_CFG: begin
                    st_d.cfg.div    = wdata[F_DIV_LO +: DIV_W];
                    st_d.cfg.inv_de = wdata[B_INV_DE];
                    st_d.cfg.inv_pc = wdata[B_INV_PC];
                    st_d.cfg.inv_hs = wdata[B_INV_HS];
                    st_d.cfg.inv_vs = wdata[B_INV_VS];
                end
                A_IEN: st_d.ien = wdata[B_EOF];
                A_IST: if (wdata[B_EOF]) st_d.eof = 1'b0;
                default: ;
            endcase
        end
        // a new end of frame wins over a clear in the same cycle
        if (eof_set) st_d.eof = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: RST_CFG, ien: 1'b0, eof: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_SIZE: begin
                rdata[F_WU_LO +: WU_W] = st_q.cfg.w_units;
                rdata[F_H_LO +: HT_W]  = st_q.cfg.height;
            end
            A_HTIM: begin
                rdata[F_SW_LO +: SW_W] = st_q.cfg.hsw;
                rdata[F_FP_LO +: PR_W] = st_q.cfg.hfp;
                rdata[F_BP_LO +: PR_W] = st_q.cfg.hbp;
            end
            A_VTIM: begin
                rdata[F_SW_LO +: SW_W] = st_q.cfg.vsw;
                rdata[F_FP_LO +: PR_W] = st_q.cfg.vfp;
                rdata[F_BP_LO +: PR_W] = st_q.cfg.vbp;
            end
            A_CFG: begin
                rdata[F_DIV_LO +: DIV_W] = st_q.cfg.div;
                rdata[B_INV_DE]          = st_q.cfg.inv_de;
                rdata[B_INV_PC]          = st_q.cfg.inv_pc;
                rdata[B_INV_HS]          = st_q.cfg.inv_hs;
                rdata[B_INV_VS]          = st_q.cfg.inv_vs;
            end
            A_IEN:   rdata[B_EOF] = st_q.ien;
            A_IST:   rdata[B_EOF] = st_q.eof;
            default: ;
        endcase
    end

    assign cfg    = st_q.cfg;
    assign ien    = st_q.ien;
    assign eof_st = st_q.eof;
    assign irq    = st_q.ien & st_q.eof;

endmodule

// File: rtl/panel_tgen_pixdiv.sv
module panel_tgen_pixdiv
    import panel_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] ratio_m1,
    output logic             pclk_en
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       fire;

    // >= lets a lowered ratio take effect without running the counter out
    assign fire = (st_q.cnt >= ratio_m1);

    always_comb begin
        st_d = st_q;
        if (fire) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pclk_en = fire;

endmodule

// File: rtl/panel_tgen_scan.sv
module panel_tgen_scan
    import panel_tgen_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int RST_WUNITS = 4,
    parameter int RST_HEIGHT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pclk_en,
    input  tgen_cfg_t        cfg_prog,
    output tgen_cfg_t        live,
    output logic [CNT_W-1:0] x_cnt,
    output logic [CNT_W-1:0] y_cnt,
    output logic             frame_start,
    output logic             eof_pulse,
    output logic             act,
    output logic             hs_raw,
    output logic             vs_raw
);

    localparam tgen_cfg_t      RST_CFG = reset_cfg(RST_WUNITS, RST_HEIGHT);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    typedef struct packed {
        tgen_cfg_t        live;
        logic [CNT_W-1:0] x;
        logic [CNT_W-1:0] y;
    } scan_state_t;

    scan_state_t st_d, st_q;

    logic [CNT_W-1:0] w_px, hs_start, hs_end, h_last;
    logic [CNT_W-1:0] v_act, vs_start, vs_end, v_last;
    logic             x_end, y_end;

    // segment boundaries, with the horizontal biases put back
    always_comb begin
        w_px     = CNT_W'({st_q.live.w_units, {UNIT_SH{1'b0}}});
        hs_start = w_px + CNT_W'(st_q.live.hfp) + CNT_W'(HFP_BIAS);
        hs_end   = hs_start + CNT_W'(st_q.live.hsw) + CNT_W'(HSW_BIAS);
        h_last   = hs_end + CNT_W'(st_q.live.hbp) + CNT_W'(HBP_BIAS) - ONE;
        v_act    = CNT_W'(st_q.live.height);
        vs_start = v_act + CNT_W'(st_q.live.vfp);
        vs_end   = vs_start + CNT_W'(st_q.live.vsw);
        v_last   = vs_end + CNT_W'(st_q.live.vbp) - ONE;
    end

    assign x_end       = (st_q.x == h_last);
    assign y_end       = (st_q.y == v_last);
    assign frame_start = pclk_en && x_end && y_end;
    assign eof_pulse   = pclk_en && (st_q.x == w_px - ONE) && (st_q.y == v_act - ONE);
    assign act         = (st_q.x < w_px) && (st_q.y < v_act);
    assign hs_raw      = (st_q.x >= hs_start) && (st_q.x < hs_end);
    assign vs_raw      = (st_q.y >= vs_start) && (st_q.y < vs_end);

    always_comb begin
        st_d = st_q;
        if (pclk_en) begin
            if (x_end) begin
                st_d.x = '0;
                if (y_end) begin
                    st_d.y    = '0;
                    st_d.live = cfg_prog;
                end else begin
                    st_d.y = st_q.y + ONE;
                end
            end else begin
                st_d.x = st_q.x + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{live: RST_CFG, x: '0, y: '0};
        else        st_q <= st_d;
    end

    assign live  = st_q.live;
    assign x_cnt = st_q.x;
    assign y_cnt = st_q.y;

endmodule

// File: rtl/panel_tgen.sv
module panel_tgen
    import panel_tgen_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int DATA_W     = 18,
    parameter int RST_WUNITS = 4,
    parameter int RST_HEIGHT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [DATA_W-1:0] pix_in,
    output logic [DATA_W-1:0] pix_out,
    output logic              pclk_en,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pclk_inv,
    output logic [CNT_W-1:0]  x_cnt,
    output logic [CNT_W-1:0]  y_cnt,
    output logic              irq
);

    tgen_cfg_t        cfg_prog;
    tgen_cfg_t        live_cfg;
    logic [DIV_W-1:0] live_div;
    logic             frame_start, eof_pulse, act, hs_raw, vs_raw;
    logic             ien, eof_st;

    panel_tgen_regs #(
        .RST_WUNITS(RST_WUNITS),
        .RST_HEIGHT(RST_HEIGHT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .eof_set(eof_pulse),
        .cfg    (cfg_prog),
        .rdata  (reg_rdata),
        .ien    (ien),
        .eof_st (eof_st),
        .irq    (irq)
    );

    assign live_div = live_cfg.div;

    panel_tgen_pixdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_m1(live_div),
        .pclk_en (pclk_en)
    );

    panel_tgen_scan #(
        .CNT_W     (CNT_W),
        .RST_WUNITS(RST_WUNITS),
        .RST_HEIGHT(RST_HEIGHT)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .pclk_en    (pclk_en),
        .cfg_prog   (cfg_prog),
        .live       (live_cfg),
        .x_cnt      (x_cnt),
        .y_cnt      (y_cnt),
        .frame_start(frame_start),
        .eof_pulse  (eof_pulse),
        .act        (act),
        .hs_raw     (hs_raw),
        .vs_raw     (vs_raw)
    );

    assign hsync    = hs_raw ^ live_cfg.inv_hs;
    assign vsync    = vs_raw ^ live_cfg.inv_vs;
    assign de       = act ^ live_cfg.inv_de;
    assign pclk_inv = live_cfg.inv_pc;
    assign pix_out  = act ? pix_in : '0;

endmodule

// File: rtl/panel_tgen_chk.sv
module panel_tgen_chk
    import panel_tgen_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pclk_en,
    input logic [DIV_W-1:0] live_div,
    input tgen_cfg_t        live_cfg,
    input logic             frame_start,
    input logic             eof_pulse,
    input logic             eof_st,
    input logic             act,
    input logic             hs_raw,
    input logic             vs_raw,
    input logic [CNT_W-1:0] x_cnt,
    input logic [CNT_W-1:0] y_cnt
);

    assert_pclk_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_en && live_div != '0 && !frame_start) |=> !pclk_en);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pclk_en |=> ($stable(x_cnt) && $stable(y_cnt)));

    assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (x_cnt == '0 && y_cnt == '0));

    assert_live_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(live_cfg));

    assert_eof_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eof_pulse |=> eof_st);

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (!hs_raw && !vs_raw));

endmodule

bind panel_tgen panel_tgen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pclk_en    (pclk_en),
    .live_div   (live_div),
    .live_cfg   (live_cfg),
    .frame_start(frame_start),
    .eof_pulse  (eof_pulse),
    .eof_st     (eof_st),
    .act        (act),
    .hs_raw     (hs_raw),
    .vs_raw     (vs_raw),
    .x_cnt      (x_cnt),
    .y_cnt      (y_cnt)
);

// File: tb/panel_tgen_test.sv
`timescale 1ns/1ps
module panel_tgen_test;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [DATA_W-1:0] pix_in = '0;
    logic [DATA_W-1:0] pix_out;
    logic              pclk_en, hsync, vsync, de, pclk_inv, irq;
    logic [CNT_W-1:0]  x_cnt, y_cnt;

    always #2 clk = ~clk;

    panel_tgen #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in(pix_in),
        .pix_out(pix_out), .pclk_en(pclk_en), .hsync(hsync), .vsync(vsync),
        .de(de), .pclk_inv(pclk_inv), .x_cnt(x_cnt), .y_cnt(y_cnt), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cyc    = 0;
    int rd_rot = 0;

    // reference model state: programmed set, working set, scan
    int p_wu, p_h, p_hsw, p_hfp, p_hbp, p_vsw, p_vfp, p_vbp, p_div, p_ide, p_ipc, p_ihs, p_ivs;
    int l_wu, l_h, l_hsw, l_hfp, l_hbp, l_vsw, l_vfp, l_vbp, l_div, l_ide, l_ipc, l_ihs, l_ivs;
    int m_div, m_x, m_y, m_en, m_st;

    int pe_count, frames_seen, prev_x, prev_y;
    int frame_len[8];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        p_wu = 4; p_h = 64; p_hsw = 0; p_hfp = 0; p_hbp = 0; p_vsw = 0; p_vfp = 0; p_vbp = 0;
        p_div = 0; p_ide = 0; p_ipc = 0; p_ihs = 0; p_ivs = 0;
        l_wu = p_wu; l_h = p_h; l_hsw = 0; l_hfp = 0; l_hbp = 0; l_vsw = 0; l_vfp = 0; l_vbp = 0;
        l_div = 0; l_ide = 0; l_ipc = 0; l_ihs = 0; l_ivs = 0;
        m_div = 0; m_x = 0; m_y = 0; m_en = 0; m_st = 0;
    endtask

    function automatic logic [31:0] exp_rdata(input int a);
        logic [31:0] r;
        r = '0;
        case (a)
            0: begin r[25:20] = 6'(p_wu); r[9:0] = 10'(p_h); end
            1: begin r[31:26] = 6'(p_hsw); r[15:8] = 8'(p_hfp); r[7:0] = 8'(p_hbp); end
            2: begin r[31:26] = 6'(p_vsw); r[15:8] = 8'(p_vfp); r[7:0] = 8'(p_vbp); end
            3: begin r[5:0] = 6'(p_div); r[20] = 1'(p_ide); r[21] = 1'(p_ipc);
                     r[22] = 1'(p_ihs); r[23] = 1'(p_ivs); end
            4: r[1] = 1'(m_en);
            5: r[1] = 1'(m_st);
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_step(input bit we, input int a, input logic [31:0] d);
        int wpx, hse, ht, vt;
        bit pen, eofs, fs;
        wpx = l_wu * 16;
        hse = wpx + l_hfp + 1 + l_hsw + 1;
        ht  = hse + l_hbp + 3;
        vt  = l_h + l_vfp + l_vsw + l_vbp;
        pen  = (m_div >= l_div);
        eofs = pen && (m_x == wpx - 1) && (m_y == l_h - 1);
        fs   = 0;
        if (pen) begin
            if (m_x == ht - 1) begin
                m_x = 0;
                if (m_y == vt - 1) begin m_y = 0; fs = 1; end
                else m_y = m_y + 1;
            end else m_x = m_x + 1;
        end
        m_div = pen ? 0 : m_div + 1;
        if (we && a == 5 && d[1]) m_st = 0;
        if (eofs) m_st = 1;
        if (fs) begin
            l_wu = p_wu; l_h = p_h; l_hsw = p_hsw; l_hfp = p_hfp; l_hbp = p_hbp;
            l_vsw = p_vsw; l_vfp = p_vfp; l_vbp = p_vbp; l_div = p_div;
            l_ide = p_ide; l_ipc = p_ipc; l_ihs = p_ihs; l_ivs = p_ivs;
        end
        if (we) begin
            case (a)
                0: begin p_wu = int'(d[25:20]); p_h = int'(d[9:0]); end
                1: begin p_hsw = int'(d[31:26]); p_hfp = int'(d[15:8]); p_hbp = int'(d[7:0]); end
                2: begin p_vsw = int'(d[31:26]); p_vfp = int'(d[15:8]); p_vbp = int'(d[7:0]); end
                3: begin p_div = int'(d[5:0]); p_ide = int'(d[20]); p_ipc = int'(d[21]);
                         p_ihs = int'(d[22]); p_ivs = int'(d[23]); end
                4: m_en = int'(d[1]);
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        int wpx, hss, hse, vss, vse;
        bit act, hs, vs;
        wpx = l_wu * 16;
        hss = wpx + l_hfp + 1;
        hse = hss + l_hsw + 1;
        vss = l_h + l_vfp;
        vse = vss + l_vsw;
        act = (m_x < wpx) && (m_y < l_h);
        hs  = (m_x >= hss) && (m_x < hse);
        vs  = (m_y >= vss) && (m_y < vse);
        chk("R11", "x_cnt", 32'(x_cnt), 32'(m_x));
        chk("R11", "y_cnt", 32'(y_cnt), 32'(m_y));
        chk("R2", "pclk_en", 32'(pclk_en), 32'(m_div >= l_div));
        chk("R3", "hsync", 32'(hsync), 32'(hs ^ l_ihs[0]));
        chk("R4", "vsync", 32'(vsync), 32'(vs ^ l_ivs[0]));
        chk("R5", "de", 32'(de), 32'(act ^ l_ide[0]));
        chk("R5", "pix_out", 32'(pix_out), act ? 32'(pix_in) : 32'd0);
        chk("R6", "pclk_inv", 32'(pclk_inv), 32'(l_ipc));
        chk("R9", "irq", 32'(irq), 32'(m_st & m_en));
        chk("R10", "rdata", reg_rdata, exp_rdata(int'(reg_addr)));
    endtask

    task automatic track_frames();
        if (x_cnt == 0 && y_cnt == 0 && !(prev_x == 0 && prev_y == 0)) begin
            if (frames_seen < 8) frame_len[frames_seen] = pe_count;
            frames_seen++;
            pe_count = 0;
        end
        if (pclk_en) pe_count++;
        prev_x = int'(x_cnt);
        prev_y = int'(y_cnt);
    endtask

    task automatic tick(input bit we, input logic [2:0] a, input logic [31:0] d);
        reg_we    = we;
        reg_addr  = a;
        reg_wdata = d;
        pix_in    = DATA_W'(cyc * 37 + 5);
        @(posedge clk);
        model_step(we, int'(a), d);
        @(negedge clk);
        cyc++;
        compare_all();
        track_frames();
    endtask

    task automatic idle();
        tick(1'b0, 3'(rd_rot), 32'd0);
        rd_rot = (rd_rot + 1) % 8;
    endtask

    task automatic run_frames(input int n);
        while (frames_seen < n && cyc < 120000) idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1: reset state before the first active edge
        chk("R1", "x_cnt reset", 32'(x_cnt), 32'd0);
        chk("R1", "y_cnt reset", 32'(y_cnt), 32'd0);
        chk("R1", "irq reset", 32'(irq), 32'd0);
        chk("R1", "size reset", reg_rdata, 32'h0040_0040);
        compare_all();
        pe_count = pclk_en ? 1 : 0;
        prev_x = 0; prev_y = 0; frames_seen = 0;

        for (int i = 0; i < 16; i++) idle();
        tick(1'b0, 3'd5, 32'd0);
        chk("R1", "status reset", reg_rdata, 32'd0);
        tick(1'b0, 3'd3, 32'd0);
        chk("R1", "config reset", reg_rdata, 32'd0);

        // program the second frame while the first runs (R7)
        tick(1'b1, 3'd0, (32'd4 << 20) | 32'd64);
        tick(1'b1, 3'd1, 32'h0BFF_0102);
        tick(1'b1, 3'd2, (32'd3 << 26) | (32'd2 << 8) | 32'd1);
        tick(1'b1, 3'd3, 32'h0040_0000);
        tick(1'b1, 3'd4, 32'd2);
        tick(1'b1, 3'd6, 32'hFFFF_FFFF);
        tick(1'b0, 3'd1, 32'd0);
        chk("R10", "htim readback masks junk", reg_rdata, 32'h0800_0102);
        tick(1'b0, 3'd3, 32'd0);
        chk("R10", "cfg readback", reg_rdata, 32'h0040_0000);
        tick(1'b0, 3'd6, 32'd0);
        chk("R10", "unused address", reg_rdata, 32'd0);
        chk("R7", "hsync polarity not yet applied", 32'(hsync), 32'd0);

        run_frames(1);
        chk("R7", "first frame length (defaults)", 32'(frame_len[0]), 32'd4416);
        chk("R6", "hsync idles high once inverted", 32'(hsync), 32'd1);

        // status/enable corner cases (R8, R9)
        tick(1'b0, 3'd5, 32'd0);
        chk("R8", "status set after frame", reg_rdata, 32'd2);
        chk("R9", "irq with enable", 32'(irq), 32'd1);
        tick(1'b1, 3'd5, 32'hFFFF_FFFD);
        chk("R8", "write 0 ignored", reg_rdata, 32'd2);
        tick(1'b1, 3'd4, 32'd0);
        chk("R9", "irq masked", 32'(irq), 32'd0);
        tick(1'b0, 3'd5, 32'd0);
        chk("R9", "status kept while masked", reg_rdata, 32'd2);
        tick(1'b1, 3'd4, 32'd2);
        chk("R9", "irq unmasked", 32'(irq), 32'd1);
        tick(1'b1, 3'd5, 32'd2);
        chk("R8", "write 1 clears", reg_rdata, 32'd0);
        chk("R9", "irq after clear", 32'(irq), 32'd0);

        // third frame: new size, timing, divider and polarities
        tick(1'b1, 3'd0, (32'd5 << 20) | 32'd66);
        tick(1'b1, 3'd1, (32'd3 << 8));
        tick(1'b1, 3'd2, (32'd1 << 26) | (32'd1 << 8) | 32'd1);
        tick(1'b1, 3'd3, 32'h00B0_0002);

        run_frames(2);
        chk("R3", "second frame length", 32'(frame_len[1]), 32'd5180);
        tick(1'b0, 3'd5, 32'd0);
        chk("R8", "status set again", reg_rdata, 32'd2);
        chk("R6", "pclk_inv applied at frame start", 32'(pclk_inv), 32'd1);
        chk("R6", "vsync idles high once inverted", 32'(vsync), 32'd1);

        run_frames(3);
        chk("R4", "third frame length", 32'(frame_len[2]), 32'd6072);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule